// File: doc/BRIEF.md
# Normalize and Denormalize Unit

This unit moves 16-bit two's-complement values between plain fixed-point form and a mantissa/exponent pair. For a normalize request, the first pipeline stage counts the redundant sign bits of the sample. The second stage uses that count to shift the sample left. The result is a left-justified mantissa, and the count is reported as the exponent. For a denormalize request, the caller supplies a mantissa and an exponent. The unit shifts the mantissa arithmetically right by that exponent, which restores the fixed-point value and keeps its sign.

A block floating-point tracker runs alongside the normalize path. Software or a sequencer marks the first and last samples of a block with `blk_start` and `blk_end`. The unit keeps a running minimum of the exponents of the normalize samples in the block. When the last sample's result appears, it presents that minimum as the shared block exponent. Scaling every sample of the block by this one exponent cannot overflow any of them.

Top module: `nrm_unit`

## Requirements
- R1: With `op`=0 (normalize), `out_exp` is the number of bits directly below the MSB that equal the MSB, in the range 0 to 15. The inputs 0x0000 and 0xFFFF both report 15.
- R2: With `op`=0, `out_data` equals the input shifted left by the reported exponent, with zeros filled in. Bits 15 and 14 of the mantissa therefore differ whenever the exponent is below 15.
- R3: With `op`=1 (denormalize), `out_data` equals `in_data` shifted arithmetically right by `in_exp`, so bit 15 of the input is copied into the vacated positions. `out_exp` repeats `in_exp`.
- R4: A result appears two clock edges after the edge that accepts `in_valid`, flagged by `out_valid`. A new request may be accepted on every cycle.
- R5: While `rst_n` is low at a clock edge, `out_valid` and `blk_exp_valid` go low and `out_data`, `out_exp` and `blk_exp` go to zero.
- R6: A block runs from a normalize sample with `blk_start` high through a normalize sample with `blk_end` high. `blk_exp` carries the smallest exponent of the normalize samples in that block. `blk_exp_valid` pulses for one cycle, in the same cycle as the last sample's `out_valid`. A new `blk_start` discards the earlier minimum.
- R7: `blk_start` and `blk_end` have no effect on a denormalize request or while `in_valid` is low. No `blk_exp_valid` pulse results, and the running minimum is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 1 | 0 normalize, 1 denormalize |
| in_data | input | 16 | Fixed-point sample or mantissa |
| in_exp | input | 4 | Shift count for denormalize |
| blk_start | input | 1 | First sample of a block |
| blk_end | input | 1 | Last sample of a block |
| out_valid | output | 1 | Result strobe |
| out_data | output | 16 | Mantissa or fixed-point result |
| out_exp | output | 4 | Detected or applied exponent |
| blk_exp_valid | output | 1 | Shared block exponent strobe |
| blk_exp | output | 4 | Shared block exponent |

## Verification
The bench goes after the exponent detector's end points:
- Zero and minus one must give the full count of 15. A detector that stops one bit early reports 14 for these.
- Values like 0x7FFF and 0x8000 must give exponent 0. A detector that off-by-ones the count shifts them into the sign bit.

Denormalization is checked with negative mantissas and the largest shift. A logical shift shows up there as a positive result.

Block tests run back-to-back samples whose minimum sits in the middle of a block. They then start a second block with larger exponents, which catches a tracker that keeps the stale minimum. They also send start and end flags on denormalize and idle cycles, where a careless design would pulse `blk_exp_valid` or reset its minimum.

// File: rtl/nrm_pkg.sv
// Shared definitions for the normalize/denormalize unit.
// Assumes a single-bit operation select at the unit's edge.
package nrm_pkg;
    typedef enum logic {
        OP_NORM   = 1'b0,
        OP_DENORM = 1'b1
    } nrm_op_e;
endpackage

// File: rtl/nrm_signcount.sv
// Redundant sign bit counter (exponent detection).
// Counts how many bits directly below the MSB equal the MSB.
// Assumes W >= 2; the count saturates naturally at W-1.
module nrm_signcount #(
    parameter int W  = 16,
    parameter int EW = $clog2(W)
) (
    input  logic [W-1:0]  value,
    output logic [EW-1:0] count
);
    // Scan from the bit below the MSB down to bit 0, stopping at the first differing bit.
    always_comb begin
        logic run;
        count = '0;
        run   = 1'b1;
        for (int i = W - 2; i >= 0; i--) begin
            if (run && (value[i] == value[W-1])) begin
                count = count + EW'(1);
            end else begin
                run = 1'b0;
            end
        end
    end
endmodule

// File: rtl/nrm_shift.sv
// Bidirectional logarithmic shifter.
// right=0: logical left shift; right=1: arithmetic right shift.
// Assumes amt < W, which holds when EW = clog2(W).
module nrm_shift #(
    parameter int W  = 16,
    parameter int EW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [EW-1:0] amt,
    input  logic          right,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [0:EW];

    assign stg[0] = din;

    // One stage per amount bit, each shifting by a power of two.
    for (genvar k = 0; k < EW; k++) begin : g_stage
        localparam int SH = 2 ** k;
        logic [W-1:0] shl;
        logic [W-1:0] shr;
        assign shl = stg[k] << SH;
        assign shr = W'($signed(stg[k]) >>> SH);
        assign stg[k+1] = amt[k] ? (right ? shr : shl) : stg[k];
    end

    assign dout = stg[EW];
endmodule

// File: rtl/nrm_blkexp.sv
// Block floating-point exponent tracker.
// Keeps the minimum exponent since the last marked first sample and
// publishes it, registered, when the marked last sample updates it.
// Assumes upd is high only for samples that take part in a block.
module nrm_blkexp #(
    parameter int EW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          first,
    input  logic          last,
    input  logic [EW-1:0] exp_in,
    output logic          blk_valid,
    output logic [EW-1:0] blk_exp
);
    logic [EW-1:0] run_min;
    logic [EW-1:0] merged;

    // Fold the incoming exponent into the running minimum, restarting on first.
    always_comb begin
        if (first) begin
            merged = exp_in;
        end else if (exp_in < run_min) begin
            merged = exp_in;
        end else begin
            merged = run_min;
        end
    end

    // Hold the running minimum and publish the block result on last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_min   <= '1;
            blk_valid <= 1'b0;
            blk_exp   <= '0;
        end else begin
            blk_valid <= upd && last;
            if (upd) begin
                run_min <= merged;
            end
            if (upd && last) begin
                blk_exp <= merged;
            end
        end
    end

    // R6: after an update the running minimum never exceeds that sample's exponent.
    a_r6_min_bound: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (run_min <= $past(exp_in)));

    // R6: a published block exponent is never above the running minimum it came from.
    a_r6_pub_le_min: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> (blk_exp == run_min));
endmodule

// File: rtl/nrm_unit.sv
// Normalize / denormalize unit, two-stage pipeline.
// Stage 1 registers the sample with its detected (normalize) or
// supplied (denormalize) exponent; stage 2 registers the shift result
// and the block exponent tracker output. Assumes EXP_W = clog2(DATA_W).
module nrm_unit
    import nrm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int EXP_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op,
    input  logic [DATA_W-1:0] in_data,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic              blk_start,
    input  logic              blk_end,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [EXP_W-1:0]  out_exp,
    output logic              blk_exp_valid,
    output logic [EXP_W-1:0]  blk_exp
);
    logic [EXP_W-1:0]  det_exp;
    logic              in_norm;

    logic              s1_valid;
    nrm_op_e           s1_op;
    logic [DATA_W-1:0] s1_data;
    logic [EXP_W-1:0]  s1_exp;
    logic              s1_first;
    logic              s1_last;

    logic [DATA_W-1:0] sh_out;
    logic              out_is_norm;

    assign in_norm = (nrm_op_e'(op) == OP_NORM);

    nrm_signcount #(.W(DATA_W), .EW(EXP_W)) u_det (
        .value (in_data),
        .count (det_exp)
    );

    // Stage 1: capture the sample, its exponent and its block markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= OP_NORM;
            s1_data  <= '0;
            s1_exp   <= '0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_op    <= nrm_op_e'(op);
            s1_data  <= in_data;
            s1_exp   <= in_norm ? det_exp : in_exp;
            s1_first <= in_valid && in_norm && blk_start;
            s1_last  <= in_valid && in_norm && blk_end;
        end
    end

    nrm_shift #(.W(DATA_W), .EW(EXP_W)) u_shift (
        .din   (s1_data),
        .amt   (s1_exp),
        .right (s1_op == OP_DENORM),
        .dout  (sh_out)
    );

    // Stage 2: register the shifted value and its exponent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_exp     <= '0;
            out_is_norm <= 1'b0;
        end else begin
            out_valid   <= s1_valid;
            out_data    <= sh_out;
            out_exp     <= s1_exp;
            out_is_norm <= (s1_op == OP_NORM);
        end
    end

    nrm_blkexp #(.EW(EXP_W)) u_blk (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (s1_valid && (s1_op == OP_NORM)),
        .first     (s1_first),
        .last      (s1_last),
        .exp_in    (s1_exp),
        .blk_valid (blk_exp_valid),
        .blk_exp   (blk_exp)
    );

    // R4: every accepted request produces a result two edges later.
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R2: a normalized mantissa below full count has its top two bits different.
    a_r2_left_justified: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_norm && (out_exp != '1)) |->
            (out_data[DATA_W-1] != out_data[DATA_W-2]));

    // R3: denormalize keeps the sign of the mantissa.
    a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_norm) |=> ##1 (out_data[DATA_W-1] == $past(in_data[DATA_W-1], 2)));

    // R6: the block exponent comes with a result and does not exceed its exponent.
    a_r6_blk_with_last: assert property (@(posedge clk) disable iff (!rst_n)
        blk_exp_valid |-> (out_valid && out_is_norm && (blk_exp <= out_exp)));

    // R7: a denormalize request never triggers a block exponent pulse.
    a_r7_no_blk_on_denorm: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_norm) |=> ##1 !blk_exp_valid);
endmodule

// File: tb/sim_nrm_unit.sv
module sim_nrm_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        op;
    logic [15:0] in_data;
    logic [3:0]  in_exp;
    logic        blk_start;
    logic        blk_end;
    logic        out_valid;
    logic [15:0] out_data;
    logic [3:0]  out_exp;
    logic        blk_exp_valid;
    logic [3:0]  blk_exp;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    nrm_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .in_data(in_data), .in_exp(in_exp), .blk_start(blk_start),
        .blk_end(blk_end), .out_valid(out_valid), .out_data(out_data),
        .out_exp(out_exp), .blk_exp_valid(blk_exp_valid), .blk_exp(blk_exp)
    );

    function automatic logic [3:0] ref_exp(logic [15:0] x);
        logic [3:0] c = 0;
        for (int i = 14; i >= 0; i--) begin
            if (x[i] != x[15]) break;
            c++;
        end
        return c;
    endfunction

    function automatic logic [15:0] ref_den(logic [15:0] x, logic [3:0] e);
        return 16'($signed(x) >>> e);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        in_valid = 0; op = 0; in_data = 0; in_exp = 0; blk_start = 0; blk_end = 0;
    endtask

    // One isolated request, result checked two edges later.
    task automatic one(logic o, logic [15:0] d, logic [3:0] e, logic st, logic en,
                       logic [15:0] xd, logic [3:0] xe, string req);
        in_valid = 1; op = o; in_data = d; in_exp = e; blk_start = st; blk_end = en;
        @(negedge clk);
        idle();
        @(negedge clk);
        chk({req, " valid"}, out_valid, 1);
        chk({req, " data"}, out_data, xd);
        chk({req, " exp"}, out_exp, xe);
    endtask

    task automatic t_reset();
        rst_n = 0; idle();
        repeat (3) @(negedge clk);
        chk("R5 out_valid", out_valid, 0);
        chk("R5 blk_exp_valid", blk_exp_valid, 0);
        chk("R5 out_data", out_data, 0);
        chk("R5 out_exp", out_exp, 0);
        chk("R5 blk_exp", blk_exp, 0);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_norm();
        logic [15:0] pats [10] = '{16'h0001, 16'h4000, 16'h7FFF, 16'h8000, 16'hFFFF,
                                   16'h0000, 16'hF000, 16'h0123, 16'hC000, 16'hFFFE};
        foreach (pats[i]) begin
            logic [3:0] e = ref_exp(pats[i]);
            one(0, pats[i], 4'h0, 0, 0, pats[i] << e, e, "R1/R2 normalize");
        end
        one(0, 16'h0000, 4'h0, 0, 0, 16'h0000, 4'd15, "R1 zero full count");
        one(0, 16'hFFFF, 4'h0, 0, 0, 16'h8000, 4'd15, "R1 minus one full count");
        one(0, 16'h0123, 4'h0, 0, 0, 16'h48C0, 4'd6, "R2 mid value");
    endtask

    task automatic t_denorm();
        one(1, 16'h8000, 4'd15, 0, 0, 16'hFFFF, 4'd15, "R3 negative max shift");
        one(1, 16'h4000, 4'd14, 0, 0, 16'h0001, 4'd14, "R3 positive");
        one(1, 16'hC000, 4'd2, 0, 0, 16'hF000, 4'd2, "R3 sign fill");
        one(1, 16'h9234, 4'd0, 0, 0, 16'h9234, 4'd0, "R3 zero shift");
        one(1, 16'h48C0, 4'd6, 0, 0, ref_den(16'h48C0, 6), 4'd6, "R3 round trip");
    endtask

    // Back-to-back stream; checks each result and the block strobe.
    task automatic stream(int n, logic [15:0] d [8], logic o [8], logic [3:0] e [8],
                          logic st [8], logic en [8], logic [15:0] xd [8],
                          logic [3:0] xe [8], logic bv [8], logic [3:0] bx [8], string req);
        for (int j = 0; j <= n + 1; j++) begin
            if (j >= 2) begin
                chk({req, " R4 valid"}, out_valid, 1);
                chk({req, " data"}, out_data, xd[j-2]);
                chk({req, " exp"}, out_exp, xe[j-2]);
                chk({req, " blk_exp_valid"}, blk_exp_valid, bv[j-2]);
                if (bv[j-2]) chk({req, " blk_exp"}, blk_exp, bx[j-2]);
            end
            if (j < n) begin
                in_valid = 1; op = o[j]; in_data = d[j]; in_exp = e[j];
                blk_start = st[j]; blk_end = en[j];
            end else begin
                idle();
            end
            @(negedge clk);
        end
    endtask

    task automatic t_block();
        logic [15:0] d [8] = '{16'h0100, 16'hFF00, 16'h1234, 16'h0800,
                               16'h0003, 16'hFFFE, 0, 0};
        logic o [8] = '{0, 0, 0, 0, 0, 0, 0, 0};
        logic [3:0] e [8] = '{0, 0, 0, 0, 0, 0, 0, 0};
        logic st [8] = '{1, 0, 0, 0, 1, 0, 0, 0};
        logic en [8] = '{0, 0, 0, 1, 0, 1, 0, 0};
        logic [15:0] xd [8];
        logic [3:0] xe [8];
        logic bv [8] = '{0, 0, 0, 1, 0, 1, 0, 0};
        logic [3:0] bx [8];
        for (int i = 0; i < 8; i++) begin
            xe[i] = ref_exp(d[i]);
            xd[i] = d[i] << xe[i];
        end
        bx[3] = 4'd2;    // min of 6, 7, 2, 3: minimum sits mid-block
        bx[5] = 4'd13;   // min of 13, 14: new start drops old minimum
        stream(6, d, o, e, st, en, xd, xe, bv, bx, "R6 block");
    endtask

    task automatic t_ignore();
        logic [15:0] d [8] = '{16'h0400, 16'h2000, 16'h0050, 0, 0, 0, 0, 0};
        logic o [8] = '{0, 1, 0, 0, 0, 0, 0, 0};
        logic [3:0] e [8] = '{0, 4'd1, 0, 0, 0, 0, 0, 0};
        logic st [8] = '{1, 1, 0, 0, 0, 0, 0, 0};
        logic en [8] = '{0, 1, 1, 0, 0, 0, 0, 0};
        logic [15:0] xd [8];
        logic [3:0] xe [8];
        logic bv [8] = '{0, 0, 1, 0, 0, 0, 0, 0};
        logic [3:0] bx [8];
        xe[0] = 4'd4; xd[0] = 16'h4000;
        xe[1] = 4'd1; xd[1] = 16'h1000;
        xe[2] = 4'd8; xd[2] = 16'h5000;
        bx[2] = 4'd4;    // denormalize exponent 1 must not enter the minimum
        stream(3, d, o, e, st, en, xd, xe, bv, bx, "R7 denorm flags");
        // Flags with in_valid low: no strobe two edges later.
        blk_start = 1; blk_end = 1;
        @(negedge clk);
        idle();
        @(negedge clk);
        chk("R7 idle flags out_valid", out_valid, 0);
        chk("R7 idle flags blk_exp_valid", blk_exp_valid, 0);
    endtask

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        t_reset();
        t_norm();
        t_denorm();
        t_block();
        t_ignore();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule